// File: doc/BRIEF.md
# Three-Channel Timer Register Port

This block is the byte-wide register front end for a bank of three interval-timer channels. A host writes an 8-bit control word to port 3 and count bytes to the data ports 0, 1 and 2. It reads count bytes and status bytes back from the same data ports. The block has separate write and read address buses, so a control write and a data read can be issued in the same cycle. Each channel keeps its own access mode and counting mode, plus two byte sequencers: one for writes and one for reads.

On the write side, each channel turns the bytes it receives into a one-cycle load pulse and a 16-bit load value. These go to a counter core, which is outside this block. On the read side, the block samples each core's live count and its output level. A counter-latch command or a read-back command freezes a count snapshot, a status snapshot, or both. Reads then drain these snapshots ahead of the live count.

Each channel has these states:
- Write sequencer: `SEQ_FIRST` and `SEQ_SECOND`. A low-byte write in word mode moves it from first to second. The high-byte write that completes the load moves it back to first.
- Read sequencer: the same two states. In word mode, every live read toggles it.
- Count-snapshot tracker: `PEND_NONE`, `PEND_LO`, `PEND_HI` and `PEND_WORD`.
  - A latch moves it from none to the current access mode.
  - A read in `PEND_WORD` moves it to `PEND_HI`.
  - A read in `PEND_LO` or `PEND_HI` moves it to none.
- Status flag: not pending or pending. A request sets it and a read clears it.

Top module: `tmr_bus_regif`

## Requirements
- R1: After reset, every channel uses access mode 3 (low then high byte) and counting mode 0. Both sequencers point at the first byte, no snapshot is pending, `rd_data` is 0 and no load pulse is active.
- R2: A control word whose bits 7:6 are 0, 1 or 2 selects that channel.
  - If bits 5:4 (access mode: 1 low only, 2 high only, 3 low then high) are nonzero, the channel takes that access mode.
  - It also takes bits 3:1 as its counting mode, which appears on `chan_mode[3*ch +: 3]` one cycle later.
  - Both of its sequencers return to the first byte.
- R3: A data write in access mode 1 pulses that channel's `ld_pulse` bit for one cycle, starting the cycle after the write, with `ld_value` = {8'h00, byte}. In mode 2 the value is {byte, 8'h00}. At most one `ld_pulse` bit is high at a time.
- R4: In access mode 3, the first data write only stores the byte and produces no pulse. The second write pulses with {second byte, stored byte} and sends the write sequencer back to the first byte.
- R5: With nothing latched, a read returns a byte of the live count.
  - Mode 1 returns the low byte and mode 2 returns the high byte.
  - Mode 3 alternates low, high, low, and so on.
- R6: A control word with bits 5:4 = 0 (counter latch) snapshots the channel's live count, but only if no count snapshot is pending. Reads return the snapshot in the access mode that was current at latch time. The snapshot clears after its last byte is read. While it is pending, further latches are ignored and the live count is not seen.
- R7: A control word with bits 7:6 = 3 is a read-back command.
  - Bits 1, 2 and 3 select channels 0, 1 and 2.
  - Bit 5 low requests a count snapshot and bit 4 low requests a status snapshot. The two requests are independent.
  - Each request is ignored on a channel that already has that kind of snapshot pending.
- R8: The status byte is:
  - bit 7: the channel output level, captured when the command executes;
  - bit 6: 0;
  - bits 5:4: access mode;
  - bits 3:1: counting mode;
  - bit 0: 0.

  A pending status byte is returned by the next read, before any pending count, and is then cleared.
- R9: `rd_data` is registered: it shows the result of a read on the cycle after `rd_en`, and holds until the next read. A read of address 3 returns 0 and changes no state.
- R10: When a command and a read of the same channel fall in the same cycle:
  - the read returns data based on the state before the command;
  - a control word's sequencer reset overrides that read's sequencer step;
  - a latch request is judged against the pending state from before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address: 0-2 data ports, 3 control word |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 2 | Read address: 0-2 data ports, 3 returns 0 |
| rd_data | output | 8 | Registered read byte |
| ld_pulse | output | 3 | One-cycle load request per channel |
| ld_value | output | 48 | Load value, 16 bits per channel (channel 0 lowest) |
| chan_mode | output | 9 | Counting mode, 3 bits per channel |
| cur_count | input | 48 | Live counts from the counter cores, 16 bits per channel |
| chan_out | input | 3 | Output levels from the counter cores |

## Verification
The two functions that can coincide are a command on the control port and a read of a channel's data port. The separate read and write address buses allow both in one cycle. The bench issues latch commands, read-back commands and mode changes in the same cycle as a read of the addressed channel, in both directed cases and random traffic. It judges the outcome against a bench model. That model computes the read result from the state before the cycle, then applies the read's side effects, and last the command, with pending tests taken from the pre-cycle state.

// File: rtl/tmr_regif_pkg.sv
package tmr_regif_pkg;
    localparam int BYTE_W  = 8;
    localparam int CNT_W   = 2 * BYTE_W;
    localparam int NUM_CH  = 3;
    localparam int MODE_W  = 3;
    localparam int ADDR_W  = 2;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'd0,
        ACC_LO    = 2'd1,
        ACC_HI    = 2'd2,
        ACC_WORD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        PEND_NONE = 2'd0,
        PEND_LO   = 2'd1,
        PEND_HI   = 2'd2,
        PEND_WORD = 2'd3
    } pend_e;

    typedef enum logic {
        SEQ_FIRST  = 1'b0,
        SEQ_SECOND = 1'b1
    } seq_e;

    typedef struct packed {
        logic              set_cfg;
        acc_e              acc;
        logic [MODE_W-1:0] mode;
        logic              latch_cnt;
        logic              latch_stat;
    } chan_cmd_t;
endpackage

// File: rtl/tmr_cmd_decode.sv
module tmr_cmd_decode
    import tmr_regif_pkg::*;
(
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [BYTE_W-1:0]            wr_data,
    output chan_cmd_t [NUM_CH-1:0]       cmd_o
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_CH);

    logic       is_ctrl;
    logic [1:0] sel;
    acc_e       acc_f;

    assign is_ctrl = wr_en && (wr_addr == CTRL_ADDR);
    assign sel     = wr_data[7:6];
    assign acc_f   = acc_e'(wr_data[5:4]);

    always_comb begin
        cmd_o = '0;
        if (is_ctrl) begin
            if (sel == 2'd3) begin
                for (int ch = 0; ch < NUM_CH; ch++) begin
                    if (wr_data[ch+1]) begin
                        cmd_o[ch].latch_cnt  = !wr_data[5];
                        cmd_o[ch].latch_stat = !wr_data[4];
                    end
                end
            end else if (acc_f == ACC_LATCH) begin
                cmd_o[sel].latch_cnt = 1'b1;
            end else begin
                cmd_o[sel].set_cfg = 1'b1;
                cmd_o[sel].acc     = acc_f;
                cmd_o[sel].mode    = wr_data[3:1];
            end
        end
    end
endmodule

// File: rtl/tmr_chan_port.sv
module tmr_chan_port
    import tmr_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  chan_cmd_t         cmd,
    input  logic              wr_sel,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              rd_sel,
    input  logic [CNT_W-1:0]  live_cnt,
    input  logic              out_lvl,
    output logic              ld_pulse,
    output logic [CNT_W-1:0]  ld_val,
    output logic [MODE_W-1:0] mode_o,
    output logic [BYTE_W-1:0] rd_byte
);
    acc_e              acc_q,   acc_d;
    logic [MODE_W-1:0] mode_q,  mode_d;
    seq_e              wseq_q,  wseq_d;
    seq_e              rseq_q,  rseq_d;
    logic [BYTE_W-1:0] wlat_q,  wlat_d;
    pend_e             cpend_q, cpend_d;
    logic [CNT_W-1:0]  csnap_q, csnap_d;
    logic              spend_q, spend_d;
    logic [BYTE_W-1:0] ssnap_q, ssnap_d;
    logic              ldp_q,   ldp_d;
    logic [CNT_W-1:0]  ldv_q,   ldv_d;

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= ACC_WORD;
            mode_q  <= '0;
            wseq_q  <= SEQ_FIRST;
            rseq_q  <= SEQ_FIRST;
            wlat_q  <= '0;
            cpend_q <= PEND_NONE;
            csnap_q <= '0;
            spend_q <= 1'b0;
            ssnap_q <= '0;
            ldp_q   <= 1'b0;
            ldv_q   <= '0;
        end else begin
            acc_q   <= acc_d;
            mode_q  <= mode_d;
            wseq_q  <= wseq_d;
            rseq_q  <= rseq_d;
            wlat_q  <= wlat_d;
            cpend_q <= cpend_d;
            csnap_q <= csnap_d;
            spend_q <= spend_d;
            ssnap_q <= ssnap_d;
            ldp_q   <= ldp_d;
            ldv_q   <= ldv_d;
        end
    end

    // next-state process
    always_comb begin
        acc_d   = acc_q;
        mode_d  = mode_q;
        wseq_d  = wseq_q;
        rseq_d  = rseq_q;
        wlat_d  = wlat_q;
        cpend_d = cpend_q;
        csnap_d = csnap_q;
        spend_d = spend_q;
        ssnap_d = ssnap_q;
        ldp_d   = 1'b0;
        ldv_d   = ldv_q;

        if (wr_sel) begin
            unique case (acc_q)
                ACC_LO: begin
                    ldp_d = 1'b1;
                    ldv_d = {{BYTE_W{1'b0}}, wr_byte};
                end
                ACC_HI: begin
                    ldp_d = 1'b1;
                    ldv_d = {wr_byte, {BYTE_W{1'b0}}};
                end
                ACC_WORD: begin
                    unique case (wseq_q)
                        SEQ_FIRST: begin
                            wlat_d = wr_byte;
                            wseq_d = SEQ_SECOND;
                        end
                        SEQ_SECOND: begin
                            ldp_d  = 1'b1;
                            ldv_d  = {wr_byte, wlat_q};
                            wseq_d = SEQ_FIRST;
                        end
                    endcase
                end
                default: ;
            endcase
        end

        if (rd_sel) begin
            if (spend_q) begin
                spend_d = 1'b0;
            end else begin
                unique case (cpend_q)
                    PEND_WORD: cpend_d = PEND_HI;
                    PEND_LO,
                    PEND_HI:   cpend_d = PEND_NONE;
                    PEND_NONE: if (acc_q == ACC_WORD)
                                   rseq_d = (rseq_q == SEQ_FIRST) ? SEQ_SECOND : SEQ_FIRST;
                endcase
            end
        end

        if (cmd.latch_cnt && (cpend_q == PEND_NONE)) begin
            cpend_d = pend_e'(acc_q);
            csnap_d = live_cnt;
        end
        if (cmd.latch_stat && !spend_q) begin
            spend_d = 1'b1;
            ssnap_d = {out_lvl, 1'b0, acc_q, mode_q, 1'b0};
        end

        if (cmd.set_cfg) begin
            acc_d  = cmd.acc;
            mode_d = cmd.mode;
            wseq_d = SEQ_FIRST;
            rseq_d = SEQ_FIRST;
        end
    end

    // output process
    always_comb begin
        rd_byte = live_cnt[BYTE_W-1:0];
        if (spend_q) begin
            rd_byte = ssnap_q;
        end else begin
            unique case (cpend_q)
                PEND_HI:         rd_byte = csnap_q[CNT_W-1:BYTE_W];
                PEND_LO,
                PEND_WORD:       rd_byte = csnap_q[BYTE_W-1:0];
                PEND_NONE: begin
                    if (acc_q == ACC_HI ||
                        (acc_q == ACC_WORD && rseq_q == SEQ_SECOND))
                        rd_byte = live_cnt[CNT_W-1:BYTE_W];
                    else
                        rd_byte = live_cnt[BYTE_W-1:0];
                end
            endcase
        end
    end

    assign ld_pulse = ldp_q;
    assign ld_val   = ldv_q;
    assign mode_o   = mode_q;

    assert_ldpulse_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ldp_q |-> $past(wr_sel));
    assert_word_first_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && acc_q == ACC_WORD && wseq_q == SEQ_FIRST) |=> !ldp_q);
    assert_cfg_seq_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.set_cfg |=> (wseq_q == SEQ_FIRST && rseq_q == SEQ_FIRST));
    assert_snap_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpend_q != PEND_NONE) |=> $stable(csnap_q));
    assert_status_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel && spend_q) |=> !spend_q);
endmodule

// File: rtl/tmr_bus_regif.sv
module tmr_bus_regif
    import tmr_regif_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [BYTE_W-1:0]          wr_data,
    input  logic                       rd_en,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [BYTE_W-1:0]          rd_data,
    output logic [NUM_CH-1:0]          ld_pulse,
    output logic [NUM_CH*CNT_W-1:0]    ld_value,
    output logic [NUM_CH*MODE_W-1:0]   chan_mode,
    input  logic [NUM_CH*CNT_W-1:0]    cur_count,
    input  logic [NUM_CH-1:0]          chan_out
);
    chan_cmd_t [NUM_CH-1:0]           cmd;
    logic      [NUM_CH-1:0][BYTE_W-1:0] rd_bytes;
    logic      [BYTE_W-1:0]           rd_q;

    tmr_cmd_decode u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cmd_o   (cmd)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        tmr_chan_port u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .cmd      (cmd[g]),
            .wr_sel   (wr_en && wr_addr == ADDR_W'(g)),
            .wr_byte  (wr_data),
            .rd_sel   (rd_en && rd_addr == ADDR_W'(g)),
            .live_cnt (cur_count[g*CNT_W +: CNT_W]),
            .out_lvl  (chan_out[g]),
            .ld_pulse (ld_pulse[g]),
            .ld_val   (ld_value[g*CNT_W +: CNT_W]),
            .mode_o   (chan_mode[g*MODE_W +: MODE_W]),
            .rd_byte  (rd_bytes[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_q <= '0;
        else if (rd_en)
            rd_q <= (rd_addr < ADDR_W'(NUM_CH)) ? rd_bytes[rd_addr[1:0]] : '0;
    end

    assign rd_data = rd_q;

    assert_load_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ld_pulse));
    assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

// File: tb/tmr_bus_regif_tb.sv
module tmr_bus_regif_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0]  wr_addr = '0, rd_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic [2:0]  ld_pulse;
    logic [47:0] ld_value;
    logic [8:0]  chan_mode;
    logic [47:0] cur_count = '0;
    logic [2:0]  chan_out = '0;

    always #2 clk = ~clk;

    tmr_bus_regif dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .ld_pulse(ld_pulse), .ld_value(ld_value),
        .chan_mode(chan_mode), .cur_count(cur_count), .chan_out(chan_out)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // bench model
    int acc[3], mode[3], wseq[3], rseq[3], wlat[3];
    int cpend[3], csnap[3], spend[3], ssnap[3];
    logic [7:0]  exp_rd;
    logic [2:0]  exp_ld;
    logic [15:0] exp_val[3];

    task automatic check(string req, logic [47:0] act, logic [47:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic void model_reset();
        for (int c = 0; c < 3; c++) begin
            acc[c] = 3; mode[c] = 0; wseq[c] = 0; rseq[c] = 0; wlat[c] = 0;
            cpend[c] = 0; csnap[c] = 0; spend[c] = 0; ssnap[c] = 0;
            exp_val[c] = '0;
        end
        exp_rd = '0;
    endfunction

    function automatic logic [15:0] live(int c);
        return cur_count[c*16 +: 16];
    endfunction

    string rd_tag;

    // model of one bus cycle, computed from pre-cycle state
    function automatic void model_step(bit wr, int wa, logic [7:0] wd, bit rd, int ra);
        int pc[3], ps[3];
        for (int c = 0; c < 3; c++) begin pc[c] = cpend[c]; ps[c] = spend[c]; end
        exp_ld = '0;
        if (rd) begin
            if (ra == 3) begin
                exp_rd = 8'h00; rd_tag = "R9";
            end else if (spend[ra] != 0) begin
                exp_rd = 8'(ssnap[ra]); spend[ra] = 0; rd_tag = "R8";
            end else if (cpend[ra] != 0) begin
                exp_rd = (cpend[ra] == 2) ? 8'(csnap[ra] >> 8) : 8'(csnap[ra]);
                cpend[ra] = (cpend[ra] == 3) ? 2 : 0; rd_tag = "R6";
            end else begin
                logic [15:0] lv = live(ra);
                if (acc[ra] == 2 || (acc[ra] == 3 && rseq[ra] == 1)) exp_rd = lv[15:8];
                else exp_rd = lv[7:0];
                if (acc[ra] == 3) rseq[ra] ^= 1;
                rd_tag = "R5";
            end
        end
        if (wr) begin
            if (wa < 3) begin
                if (acc[wa] == 1) begin exp_ld[wa] = 1; exp_val[wa] = {8'h00, wd}; end
                else if (acc[wa] == 2) begin exp_ld[wa] = 1; exp_val[wa] = {wd, 8'h00}; end
                else if (wseq[wa] == 0) begin wlat[wa] = wd; wseq[wa] = 1; end
                else begin exp_ld[wa] = 1; exp_val[wa] = {wd, 8'(wlat[wa])}; wseq[wa] = 0; end
            end else begin
                int sel = wd[7:6];
                if (sel == 3) begin
                    for (int c = 0; c < 3; c++) begin
                        if (wd[c+1]) begin
                            if (!wd[5] && pc[c] == 0) begin cpend[c] = acc[c]; csnap[c] = live(c); end
                            if (!wd[4] && ps[c] == 0) begin
                                spend[c] = 1;
                                ssnap[c] = {chan_out[c], 1'b0, 2'(acc[c]), 3'(mode[c]), 1'b0};
                            end
                        end
                    end
                end else if (wd[5:4] == 2'd0) begin
                    if (pc[sel] == 0) begin cpend[sel] = acc[sel]; csnap[sel] = live(sel); end
                end else begin
                    acc[sel] = wd[5:4]; mode[sel] = wd[3:1]; wseq[sel] = 0; rseq[sel] = 0;
                end
            end
        end
    endfunction

    // one bus cycle; called at a falling edge
    task automatic op(bit wr, int wa, logic [7:0] wd, bit rd, int ra);
        wr_en = wr; wr_addr = 2'(wa); wr_data = wd;
        rd_en = rd; rd_addr = 2'(ra);
        model_step(wr, wa, wd, rd, ra);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        if (rd) check(rd_tag, 48'(rd_data), 48'(exp_rd));
        check("R3", 48'(ld_pulse), 48'(exp_ld));
        for (int c = 0; c < 3; c++)
            if (exp_ld[c]) check(wa < 3 && acc[c] == 3 ? "R4" : "R3",
                                 48'(ld_value[c*16 +: 16]), 48'(exp_val[c]));
        for (int c = 0; c < 3; c++)
            check("R2", 48'(chan_mode[c*3 +: 3]), 48'(mode[c]));
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED_1234);
        model_reset();
        cur_count = {16'h3333, 16'h2222, 16'h1111};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1", 48'(rd_data), 48'h0);
        check("R1", 48'(ld_pulse), 48'h0);
        check("R1", 48'(chan_mode), 48'h0);
        op(0, 0, 0, 1, 0);                 // R1: word mode, low byte first
        check("R1", 48'(rd_data), 48'h11);
        op(0, 0, 0, 1, 0);
        check("R5", 48'(rd_data), 48'h11);
        // R2/R3: ch1 low-only, counting mode 2
        op(1, 3, 8'b01_01_010_0, 0, 0);
        check("R2", 48'(chan_mode[5:3]), 48'd2);
        op(1, 1, 8'hA5, 0, 0);
        check("R3", 48'(ld_value[31:16]), 48'h00A5);
        // R3: ch2 high-only
        op(1, 3, 8'b10_10_101_0, 0, 0);
        op(1, 2, 8'h5A, 1, 2);
        check("R3", 48'(ld_value[47:32]), 48'h5A00);
        // R4: ch0 word write
        op(1, 0, 8'h34, 0, 0);
        op(1, 0, 8'h12, 0, 0);
        check("R4", 48'(ld_value[15:0]), 48'h1234);
        // R6: latch ch0, change live, second latch ignored
        cur_count[15:0] = 16'hBEEF;
        op(1, 3, 8'b00_00_000_0, 0, 0);
        cur_count[15:0] = 16'h0F0F;
        op(1, 3, 8'b00_00_000_0, 0, 0);
        op(0, 0, 0, 1, 0);
        check("R6", 48'(rd_data), 48'hEF);
        op(0, 0, 0, 1, 0);
        check("R6", 48'(rd_data), 48'hBE);
        op(0, 0, 0, 1, 0);
        check("R5", 48'(rd_data), 48'h0F);
        // R7/R8: read-back ch1 count and status, output high
        chan_out = 3'b010;
        cur_count[31:16] = 16'h77C3;
        op(1, 3, 8'b11_00_010_0, 0, 0);
        op(0, 0, 0, 1, 1);
        check("R8", 48'(rd_data), 48'h94);
        op(0, 0, 0, 1, 1);
        check("R7", 48'(rd_data), 48'hC3);
        // R9: address 3 reads zero
        op(0, 0, 0, 1, 3);
        check("R9", 48'(rd_data), 48'h00);
        // R10: latch and read of ch0 in one cycle
        cur_count[15:0] = 16'hCAFE;
        op(1, 3, 8'b00_00_000_0, 1, 0);
        cur_count[15:0] = 16'h0000;
        op(0, 0, 0, 1, 0);
        check("R10", 48'(rd_data), 48'hFE);
        op(1, 3, 8'b00_11_001_0, 1, 0);
        // random traffic, mostly exercising R10 coincidences
        for (int i = 0; i < 1500; i++) begin
            int kind = $urandom_range(0, 9);
            int wa = (kind < 5) ? 3 : $urandom_range(0, 3);
            logic [7:0] wd = 8'($urandom);
            if (wa == 3 && wd[7:6] != 2'd3 && $urandom_range(0, 3) == 0) wd[5:4] = 2'd0;
            cur_count = {16'($urandom), 16'($urandom), 16'($urandom)};
            chan_out = 3'($urandom);
            op($urandom_range(0, 3) != 0, wa, wd, $urandom_range(0, 2) != 0, $urandom_range(0, 3));
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule